// File: doc/BRIEF.md
# Quarter-Duty LCD Multiplex Sequencer

This block runs from the display oscillator and drives a four-backplane, one-third-bias liquid crystal panel. It does not produce voltages. It produces a 2-bit level code for each backplane pin and each frontplane pin, and analog buffers downstream turn the codes into voltages. The codes are 0 for 0 V, 1 for one third of the LCD supply, 2 for two thirds and 3 for the full supply. The oscillator is divided by `HALF_DIV` to form a half-period. Two half-periods make one backplane phase, and four phases make one frame. In the second half of every phase each code is replaced by its bitwise complement, so that no pixel sees a DC voltage.

A latched pattern of `ROWS*COLS` bits arrives from the data side. At the start of each phase the block captures the group of `COLS` bits that belongs to that phase and holds it for the whole phase.

Several drivers can share one panel. One of them is the master and produces the frame sync pulse. The others are slaves and restart their sequence when the incoming sync rises.

Top module: `lcd_quad_mux`

## Requirements
- R1: Backplanes 1 to 4 (phase index 0 to 3) become active in increasing order and then wrap. Exactly one backplane is active at any time.
- R2: Backplane `i` drives code field `bp_lvl[2i+1:2i]`. While active, it gives code 3 in the first half and code 0 in the second half. While inactive, it gives code 1 in the first half and code 2 in the second half.
- R3: Frontplane `j` drives code field `fp_lvl[2j+1:2j]`. When its data bit is 1, it gives code 0 in the first half and code 3 in the second half. When its bit is 0, it gives code 2 in the first half and code 1 in the second half.
- R4: During phase `p`, frontplane `j` uses bit `pattern[p*COLS+j]`, sampled on the clock edge that starts the phase. A change to `pattern` later in the same phase has no effect until the next phase starts.
- R5: Each half-period lasts exactly `HALF_DIV` clocks, so one frame lasts `8*HALF_DIV` clocks.
- R6: In master mode, `sync_out` is 1 for the whole first half of backplane 1 and 0 at all other times. In slave mode, `sync_out` is always 0.
- R7: In master mode, `sync_in` has no effect on the sequence.
- R8: In slave mode, a clock edge that samples `sync_in` as 1, after the previous edge sampled it as 0, moves the block to the first half of backplane 1. This edge restarts the divider and loads group 0 of the pattern. Holding `sync_in` at 1 causes no further restarts.
- R9: While reset is active, the block sits in the first half of backplane 1 and every frontplane is off (code 2). Group 0 of the pattern is loaded on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 selects master mode, 0 selects slave mode |
| sync_in | input | 1 | Frame sync from the master, used in slave mode only |
| pattern | input | ROWS*COLS | Latched display pattern, group p at bits p*COLS upward |
| sync_out | output | 1 | Frame sync pulse, master mode only |
| bp_lvl | output | 2*ROWS | Backplane level codes, 2 bits per backplane |
| fp_lvl | output | 2*COLS | Frontplane level codes, 2 bits per frontplane |

## Verification
The hardest case to reach is a slave resync that lands in the middle of a half-period of a later phase. After such a resync, the divider, the half bit, the phase and the captured group must all restart together. A sync input that stays high afterwards must not restart anything again. The bench switches the block to slave mode and lets it run into backplane 3. It then raises `sync_in` for a single clock at an odd offset inside a half, and later holds the input high for several frames. A second hard case is a pattern change in the middle of a phase. The bench rewrites the pattern partway through backplane 2 and checks that the frontplanes show the new data only from the next phase boundary.

// File: rtl/lcd_quad_mux.sv
module lcd_quad_mux #(
  parameter int HALF_DIV = 64,
  parameter int ROWS     = 4,
  parameter int COLS     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_master,
  input  logic                 sync_in,
  input  logic [ROWS*COLS-1:0] pattern,
  output logic                 sync_out,
  output logic [2*ROWS-1:0]    bp_lvl,
  output logic [2*COLS-1:0]    fp_lvl
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(ROWS - 1);

  logic [DW-1:0]   div;
  logic            half;
  logic [PW-1:0]   phase;
  logic [COLS-1:0] grp;
  logic            fresh;
  logic            sync_d;

  wire           tick     = (div == DIV_LAST);
  wire           rise     = !is_master && sync_in && !sync_d;
  wire [PW-1:0]  phase_nx = (phase == PH_LAST) ? '0 : phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      half   <= 1'b0;
      phase  <= '0;
      grp    <= '0;
      fresh  <= 1'b1;
      sync_d <= 1'b0;
    end else begin
      sync_d <= sync_in;
      fresh  <= 1'b0;
      if (rise) begin
        div   <= '0;
        half  <= 1'b0;
        phase <= '0;
        grp   <= pattern[COLS-1:0];
      end else begin
        if (fresh) grp <= pattern[COLS-1:0];
        if (tick) begin
          div  <= '0;
          half <= ~half;
          if (half) begin
            phase <= phase_nx;
            grp   <= pattern[int'(phase_nx)*COLS +: COLS];
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  logic [ROWS-1:0] act;

  for (genvar i = 0; i < ROWS; i++) begin : g_bp
    assign bp_lvl[2*i +: 2] = (phase == PW'(i)) ? (half ? 2'd0 : 2'd3)
                                                : (half ? 2'd2 : 2'd1);
    assign act[i] = (bp_lvl[2*i+1] == bp_lvl[2*i]);
  end

  for (genvar j = 0; j < COLS; j++) begin : g_fp
    assign fp_lvl[2*j +: 2] = grp[j] ? (half ? 2'd3 : 2'd0)
                                     : (half ? 2'd1 : 2'd2);
  end

  assign sync_out = is_master && (phase == '0) && !half;

  // R1
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) == 1);

  // R2
  // R3
  dc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !half && !rise && !fresh) |=>
      (bp_lvl == ~$past(bp_lvl)) && (fp_lvl == ~$past(fp_lvl)));

  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rise && !fresh) |=> $stable(bp_lvl) && $stable(fp_lvl));

  // R6
  sync_on_bp1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (bp_lvl[1:0] == 2'd3));
endmodule

// File: tb/tb_lcd_quad_mux.sv
module tb_lcd_quad_mux;
  localparam int N = 3;
  localparam int R = 4;
  localparam int C = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           is_master = 1'b1;
  logic           sync_in = 1'b0;
  logic [R*C-1:0] pattern = '0;
  logic           sync_out;
  logic [2*R-1:0] bp_lvl;
  logic [2*C-1:0] fp_lvl;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lcd_quad_mux #(.HALF_DIV(N), .ROWS(R), .COLS(C)) dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .sync_in(sync_in),
    .pattern(pattern), .sync_out(sync_out), .bp_lvl(bp_lvl), .fp_lvl(fp_lvl));

  // Reference timeline: k = clocks since the last restart, gm = expected group
  int       k;
  logic [C-1:0] gm;
  logic     fresh_m, sd_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k <= 0; gm <= '0; fresh_m <= 1'b1; sd_m <= 1'b0;
    end else begin
      sd_m <= sync_in;
      fresh_m <= 1'b0;
      if (!is_master && sync_in && !sd_m) begin
        k <= 0;
        gm <= pattern[C-1:0];
      end else begin
        k <= k + 1;
        if (((k + 1) % (2*N)) == 0)
          gm <= pattern[(((k + 1) / (2*N)) % R) * C +: C];
        else if (fresh_m)
          gm <= pattern[C-1:0];
      end
    end
  end

  task automatic check(string tag);
    int ph = (k / (2*N)) % R;
    int hf = (k / N) % 2;
    logic [2*R-1:0] ebp;
    logic [2*C-1:0] efp;
    logic es;
    for (int i = 0; i < R; i++)
      ebp[2*i +: 2] = (i == ph) ? (hf ? 2'd0 : 2'd3) : (hf ? 2'd2 : 2'd1);
    for (int j = 0; j < C; j++)
      efp[2*j +: 2] = gm[j] ? (hf ? 2'd3 : 2'd0) : (hf ? 2'd1 : 2'd2);
    es = is_master && ph == 0 && hf == 0;
    checks += 3;
    if (bp_lvl !== ebp) begin
      failures++;
      $display("FAIL R1/R2 %s k=%0d bp_lvl=%h expected %h", tag, k, bp_lvl, ebp);
    end
    if (fp_lvl !== efp) begin
      failures++;
      $display("FAIL R3/R4 %s k=%0d fp_lvl=%h expected %h", tag, k, fp_lvl, efp);
    end
    if (sync_out !== es) begin
      failures++;
      $display("FAIL R6 %s k=%0d sync_out=%b expected %b", tag, k, sync_out, es);
    end
  endtask

  task automatic run(int n, string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    is_master = 1'b1;
    pattern = {32'h0F0F_1234, 32'hA5A5_5A5A, 32'h0000_FFFF, 32'hDEAD_BEEF};
    repeat (3) @(negedge clk);
    check("R9 reset state");
    rst_n = 1'b1;
    check("R9 after release");
  endtask

  task automatic t_master_frames();
    run(2 * 8 * N + 1, "R1 R2 R3 R5 R6 master frames");
  endtask

  task automatic t_midphase();
    while (((k / (2*N)) % R) != 1 || (k % (2*N)) != N - 1) run(1, "R4 seek");
    pattern = ~pattern;
    run(3 * N, "R4 mid-phase change");
  endtask

  task automatic t_master_ignore();
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); sync_in = 1'b1; check("R7 sync pulse in master");
      @(negedge clk); sync_in = 1'b0; check("R7 sync pulse in master");
      run(5, "R7 after pulse");
    end
  endtask

  task automatic t_slave();
    is_master = 1'b0;
    pattern = {32'h1111_2222, 32'h3333_4444, 32'h8000_0001, 32'hCAFE_F00D};
    while (((k / (2*N)) % R) != 2 || (k % N) != 1) run(1, "R8 seek");
    sync_in = 1'b1;
    run(1, "R8 resync edge");
    sync_in = 1'b0;
    run(8 * N, "R8 R6 after resync");
    while ((k % N) != 2) run(1, "R8 seek");
    sync_in = 1'b1;
    run(3 * 8 * N, "R8 held high");
    sync_in = 1'b0;
    run(8 * N, "R8 R5 slave free run");
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_master_frames();
    t_midphase();
    t_master_ignore();
    t_slave();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule